// File: doc/BRIEF.md
# Four-Way Exact LRU Victim Selector

This block keeps the exact age order of the ways of one cache set and names the way to evict. Age is stored as one flag per unordered pair of ways. Flag `hi*(hi-1)/2 + lo` (with `lo < hi`) is 1 when way `hi` was touched more recently than way `lo`. With the default of four ways this gives six flags. A touch strobe with a way index makes that way the newest. A valid mask picks between two victim rules: an empty (invalid) way if there is one, otherwise the oldest way.

The victim output is purely combinational and comes from the state held before the next clock edge. A cache controller can therefore read the victim and report the refill in the same cycle. The order changes only at the following edge. The block holds one set. A multi-set cache places one copy per set, or stores the flag vector in its own array.

Top module: `lru4_tracker`

## Requirements
- R1: A synchronous active-high reset sets every pair flag to 1. This orders the ways from way 0 (oldest) to way WAYS-1 (newest). After reset, touching the reported victim each cycle with all ways valid yields victims 0,1,2,3,0.
- R2: When `touch_en` is high at a clock edge, the way on `touch_way` becomes the newest. The relative order of the other ways is kept.
- R3: The flag at bit `hi*(hi-1)/2 + lo` (`lo < hi`) is 1 exactly when way `hi` is newer than way `lo`. After a touch of way w, every flag pairing w with a lower way is 1, and every flag pairing w with a higher way is 0.
- R4: With `touch_en` low, the order does not change, whatever value `touch_way` has.
- R5: When all bits of `way_valid` are 1, `victim` is the oldest way.
- R6: When any bit of `way_valid` is 0, `victim` is the lowest-numbered way whose valid bit is 0 (bit k of `way_valid` belongs to way k).
- R7: `victim` reflects the order held before the current edge. A touch shows in `victim` only after the edge that records it.
- R8: Over long mixed sequences of touches and valid masks, `victim` matches an ordered-list model of the set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| touch_en | input | 1 | Records a use of `touch_way` at the clock edge |
| touch_way | input | $clog2(WAYS) | Index of the way being used |
| way_valid | input | WAYS | Per-way valid flags, bit k for way k |
| victim | output | $clog2(WAYS) | Way to replace, combinational |

## Verification
The bench builds the block with WAYS at its default of four. This keeps the ordered-list model small: 24 orderings and 16 valid masks. A few thousand random steps then visit every ordering with full and partial masks. The same width lets a fixed vector table walk through chosen orderings, repeated touches of the newest way, and the empty-way priority cases, with expected victims worked out by hand.

// File: rtl/lru_pkg.sv
package lru_pkg;

    // Upper bound on flag count seen by the helper functions (16 ways).
    localparam int MAX_PAIRS = 120;

    function automatic int pair_count(input int ways);
        return ways * (ways - 1) / 2;
    endfunction

    // Flag index for the pair (lo, hi) with lo < hi.
    function automatic int pair_idx(input int lo, input int hi);
        return hi * (hi - 1) / 2 + lo;
    endfunction

    // Way w is older than every other way.
    function automatic logic is_oldest(input logic [MAX_PAIRS-1:0] st,
                                       input int ways, input int w);
        logic r;
        r = 1'b1;
        for (int o = 0; o < ways; o++) begin
            if (o < w)      r = r & ~st[pair_idx(o, w)];
            else if (o > w) r = r &  st[pair_idx(w, o)];
        end
        return r;
    endfunction

    // Way w is newer than every other way.
    function automatic logic is_newest(input logic [MAX_PAIRS-1:0] st,
                                       input int ways, input int w);
        logic r;
        r = 1'b1;
        for (int o = 0; o < ways; o++) begin
            if (o < w)      r = r &  st[pair_idx(o, w)];
            else if (o > w) r = r & ~st[pair_idx(w, o)];
        end
        return r;
    endfunction

endpackage

// File: rtl/lru_order_reg.sv
module lru_order_reg #(
    parameter int WAYS = 4,
    localparam int IW = $clog2(WAYS),
    localparam int PB = lru_pkg::pair_count(WAYS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_way,
    output logic [PB-1:0] order_q
);
    import lru_pkg::*;

    logic [PB-1:0] order_d;

    always_comb begin
        order_d = order_q;
        if (touch_en) begin
            for (int hi = 1; hi < WAYS; hi++) begin
                for (int lo = 0; lo < hi; lo++) begin
                    if (touch_way == IW'(hi))
                        order_d[pair_idx(lo, hi)] = 1'b1;
                    else if (touch_way == IW'(lo))
                        order_d[pair_idx(lo, hi)] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) order_q <= '1;
        else     order_q <= order_d;
    end

    logic [MAX_PAIRS-1:0] order_ext;
    assign order_ext = MAX_PAIRS'(order_q);

    assert_reset_order_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&order_q));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(touch_en)) |-> $stable(order_q));

    for (genvar w = 0; w < WAYS; w++) begin : g_newest_chk
        assert_touch_newest_R3: assert property (@(posedge clk) disable iff (rst)
            (touch_en && touch_way == IW'(w)) |=> is_newest(order_ext, WAYS, w));
    end

endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
    parameter int WAYS = 4,
    localparam int IW = $clog2(WAYS),
    localparam int PB = lru_pkg::pair_count(WAYS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PB-1:0]   order_q,
    input  logic [WAYS-1:0] way_valid,
    output logic [IW-1:0]   victim
);
    import lru_pkg::*;

    logic [MAX_PAIRS-1:0] order_ext;
    logic [WAYS-1:0]      oldest_vec;
    logic [WAYS-1:0]      empty_vec;
    logic                 have_empty;

    assign order_ext = MAX_PAIRS'(order_q);
    assign empty_vec = ~way_valid;
    assign have_empty = |empty_vec;

    for (genvar k = 0; k < WAYS; k++) begin : g_age
        assign oldest_vec[k] = is_oldest(order_ext, WAYS, k);
    end

    always_comb begin
        logic found;
        found  = 1'b0;
        victim = '0;
        for (int k = 0; k < WAYS; k++) begin
            if (!found && empty_vec[k]) begin
                victim = IW'(k);
                found  = 1'b1;
            end
        end
        if (!have_empty) begin
            for (int k = 0; k < WAYS; k++) begin
                if (oldest_vec[k]) victim = IW'(k);
            end
        end
    end

    assert_single_oldest_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot(oldest_vec));

    assert_full_pick_oldest_R5: assert property (@(posedge clk) disable iff (rst)
        (&way_valid) |-> oldest_vec[victim]);

    assert_empty_first_R6: assert property (@(posedge clk) disable iff (rst)
        (!(&way_valid)) |-> !way_valid[victim]);

    assert_lowest_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (!(&way_valid)) |->
            ((way_valid & ((WAYS'(1) << victim) - WAYS'(1)))
             == ((WAYS'(1) << victim) - WAYS'(1))));

endmodule

// File: rtl/lru4_tracker.sv
module lru4_tracker #(
    parameter int WAYS = 4,
    localparam int IW = $clog2(WAYS),
    localparam int PB = lru_pkg::pair_count(WAYS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            touch_en,
    input  logic [IW-1:0]   touch_way,
    input  logic [WAYS-1:0] way_valid,
    output logic [IW-1:0]   victim
);

    logic [PB-1:0] order_q;

    lru_order_reg #(.WAYS(WAYS)) u_order (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (touch_en),
        .touch_way (touch_way),
        .order_q   (order_q)
    );

    lru_victim_pick #(.WAYS(WAYS)) u_pick (
        .clk       (clk),
        .rst       (rst),
        .order_q   (order_q),
        .way_valid (way_valid),
        .victim    (victim)
    );

    // R7: victim must not move within a cycle unless its inputs do.
    assert_victim_steady_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(touch_en) && $stable(way_valid)) |-> $stable(victim));

endmodule

// File: tb/sim_lru4_tracker.sv
`timescale 1ns/1ps
module sim_lru4_tracker;
    localparam int WAYS = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       touch_en = 1'b0;
    logic [1:0] touch_way = 2'd0;
    logic [3:0] way_valid = 4'hF;
    logic [1:0] victim;

    int total = 0;
    int bad = 0;
    int order [4];
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lru4_tracker #(.WAYS(WAYS)) u0 (
        .clk(clk), .rst(rst), .touch_en(touch_en), .touch_way(touch_way),
        .way_valid(way_valid), .victim(victim)
    );

    // {touch_en, touch_way, way_valid, expected victim}
    localparam logic [8:0] VEC [15] = '{
        {1'b0, 2'd0, 4'hF, 2'd0},
        {1'b1, 2'd0, 4'hF, 2'd0},
        {1'b0, 2'd0, 4'hF, 2'd1},
        {1'b1, 2'd2, 4'hF, 2'd1},
        {1'b0, 2'd0, 4'hF, 2'd1},
        {1'b1, 2'd1, 4'hF, 2'd1},
        {1'b0, 2'd0, 4'hF, 2'd3},
        {1'b0, 2'd0, 4'b0111, 2'd3},
        {1'b0, 2'd0, 4'b1010, 2'd0},
        {1'b0, 2'd0, 4'b0000, 2'd0},
        {1'b0, 2'd0, 4'b1011, 2'd2},
        {1'b1, 2'd3, 4'hF, 2'd3},
        {1'b0, 2'd0, 4'hF, 2'd0},
        {1'b1, 2'd3, 4'hF, 2'd0},
        {1'b0, 2'd0, 4'hF, 2'd0}
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 4; k++) order[k] = k;
    endtask

    task automatic model_touch(input int w);
        int pos = 0;
        for (int k = 0; k < 4; k++) if (order[k] == w) pos = k;
        for (int k = pos; k < 3; k++) order[k] = order[k+1];
        order[3] = w;
    endtask

    function automatic logic [1:0] model_victim(input logic [3:0] v);
        for (int k = 0; k < 4; k++) if (!v[k]) return 2'(k);
        return 2'(order[0]);
    endfunction

    task automatic step(input logic en, input logic [1:0] w, input logic [3:0] v,
                        input logic [1:0] exp, input string req);
        @(negedge clk);
        touch_en = en; touch_way = w; way_valid = v;
        #1;
        check(req, victim, exp);
        if (en) model_touch(int'(w));
    endtask

    initial begin
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1 during reset", victim, 2'd0);
        rst = 1'b0;

        // Vector table walk
        for (int i = 0; i < 15; i++)
            step(VEC[i][8], VEC[i][7:6], VEC[i][5:2], VEC[i][1:0],
                 "table R2 R3 R5 R6 R7");

        // Order now 0,2,1,3 (oldest first). Idle with every touch_way value.
        for (int i = 0; i < 4; i++)
            step(1'b0, 2'(i), 4'hF, 2'd0, "R4 idle touch_way ignored");
        step(1'b1, 2'd0, 4'hF, 2'd0, "R7 pre-update victim");
        step(1'b0, 2'd0, 4'hF, 2'd2, "R2 after touch of oldest");

        // Reset mid-run, with a touch held during reset
        @(negedge clk);
        rst = 1'b1; touch_en = 1'b1; touch_way = 2'd0;
        @(negedge clk);
        rst = 1'b0; touch_en = 1'b0;
        model_reset();
        step(1'b1, 2'd0, 4'hF, 2'd0, "R1 reset walk");
        step(1'b1, 2'd1, 4'hF, 2'd1, "R1 reset walk");
        step(1'b1, 2'd2, 4'hF, 2'd2, "R1 reset walk");
        step(1'b1, 2'd3, 4'hF, 2'd3, "R1 reset walk");
        step(1'b0, 2'd0, 4'hF, 2'd0, "R1 reset walk wrap");

        // Random sequences against the ordered-list model
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] v;
            logic [1:0] w;
            logic       e;
            v = ($urandom % 2 == 0) ? 4'hF : 4'($urandom);
            w = 2'($urandom % 4);
            e = ($urandom % 4) != 0;
            step(e, w, v, model_victim(v), "R8 random");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule